// File: doc/BRIEF.md
# Multi-Rail Power-Good Aggregator

This block reduces the status of six switchable supply rails into one active-low power-good pin. Each rail supplies an enable and an in-regulation flag. The in-regulation flag is produced by an analog window comparator elsewhere and means "within 10% of target". The pin is modelled as open-drain: one output says whether the pin is actively pulled low, and the other gives the level the pin settles to with an external pull-up. The always-on seventh rail does not feed this block.

A rail that is switched off never pulls the pin low. A rail that has just been switched on pulls it low until it settles. The in-regulation flags arrive from another clock domain and pass through a two-flop synchronizer. After each enable edge, a settle window blanks the rail for a fixed number of cycles, so a stale "good" flag cannot release the pin early.

The core rail (index 2) can be moved between programmed voltages. While such a move is in progress, its out-of-regulation flag is ignored, but only after the rail has reached regulation at least once since it was last enabled. With no rail enabled, or during input undervoltage lockout, the pin is held low. Without backup supply the pin floats. All outputs are registered.

Top module: `pgc_combiner`

## Requirements
- R1: With backup present and no lockout, if any enabled rail has its in-regulation bit at 0 (after synchronization and any settle window), `pg_pull_en` is 1 and `pg_pin_level` is 0. If every enabled rail reads 1, `pg_pull_en` is 0.
- R2: The in-regulation bit of a rail whose `rail_en` bit is 0 has no effect on the outputs.
- R3: When `rail_en` is all zeros and backup is present, `pg_pull_en` is 1.
- R4: For the core rail (bit 2), an out-of-regulation flag is ignored while `core_slewing` is 1, provided the rail has read in-regulation (outside its settle window) since its enable last rose. Before that first good reading, `core_slewing` masks nothing, and once it drops to 0 the fault shows again.
- R5: On a rising edge of any `rail_en` bit, `pg_pull_en` is 1 from the first clock edge that sees the rise through the following SETTLE_CYCLES edges, whatever that rail's flag says. It returns to 0 on the next edge if all enabled rails are in regulation.
- R6: While `uvlo_active` is 1 and backup is present, `pg_pull_en` is 1.
- R7: While `backup_ok` is 0, `pg_pull_en` is 0 and `pg_pin_level` is 1, whatever the other inputs are.
- R8: During and directly after reset, `pg_pull_en` is 1 and `pg_pin_level` is 0.
- R9: A change of `rail_ok_async` first shows at the outputs after the third rising clock edge that follows it (two synchronizer flops plus the output register).
- R10: `pg_pin_level` is always the inverse of `pg_pull_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_en | input | NUM_RAILS | Per-rail enable, bit 2 is the core rail |
| rail_ok_async | input | NUM_RAILS | Per-rail in-regulation flag, asynchronous |
| core_slewing | input | 1 | Core rail is moving between programmed voltages |
| uvlo_active | input | 1 | Input supply is in undervoltage lockout |
| backup_ok | input | 1 | Backup supply present; pin is inert without it |
| pg_pin_level | output | 1 | Pin level with pull-up: 1 good or floating, 0 pulled low |
| pg_pull_en | output | 1 | 1 when the open-drain pin is actively driven low |

## Verification
The main function is tried with a table of rail patterns:
- all rails on and good, and a single rail faulty, which separate R1's OR reduction from a per-bit test;
- faulty flags on disabled rails, which show whether the enable mask works;
- the core fault with and without the slewing flag, which tells masking from ignoring the core rail outright;
- lockout and missing backup overlaid on otherwise good patterns, which set forced-low apart from floating.

Directed cases then pin down the exact cycle of release after an enable rise and the three-edge synchronizer latency. They also cover slewing before the core rail's first good reading, which must not mask a fault.

// File: rtl/pgc_pkg.sv
// Package pgc_pkg
// Shared helpers for the power-good aggregator.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package pgc_pkg;

    // Width of a down-counter that must hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        cnt_width = (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pgc_sync.sv
// Module pgc_sync
// Two-flop synchronizer for a vector of independent level flags.
// Assumes: each bit is a slow level whose bits need no mutual coherence.
module pgc_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: shift the asynchronous flags through two flops; reset reads "not good".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;

endmodule

// File: rtl/pgc_rail_qual.sv
// Module pgc_rail_qual
// Qualifies one rail: blanks it for SETTLE_CYCLES after its enable rises,
// masks it when disabled and, for the core rail, masks out-of-regulation
// while a voltage move is in progress once the rail has been good.
// Assumes: en and busy are synchronous to clk; ok_s is already synchronized.
module pgc_rail_qual
    import pgc_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 4,
    parameter bit          IS_CORE       = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ok_s,
    input  logic busy,
    output logic fault
);

    localparam int unsigned CW = cnt_width(SETTLE_CYCLES);
    localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYCLES);
    localparam logic CORE_BIT = IS_CORE;

    logic          en_q;
    logic [CW-1:0] settle_cnt_q;
    logic          seen_good_q;
    logic          en_rise;
    logic          blank;
    logic          slew_mask;

    assign en_rise   = en & ~en_q;
    assign blank     = en_rise | (settle_cnt_q != '0);
    assign slew_mask = CORE_BIT & busy & seen_good_q;
    assign fault     = en & (blank | (~ok_s & ~slew_mask));

    // Purpose: remember the previous enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Purpose: settle-window counter loaded on enable rise, cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)          settle_cnt_q <= '0;
        else if (en_rise)           settle_cnt_q <= CNT_LOAD;
        else if (settle_cnt_q != '0) settle_cnt_q <= settle_cnt_q - 1'b1;
    end

    // Purpose: track whether the rail has been seen in regulation since its enable rose.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)        seen_good_q <= 1'b0;
        else if (ok_s && !blank)  seen_good_q <= 1'b1;
    end

endmodule

// File: rtl/pgc_combiner.sv
// Module pgc_combiner (top)
// Combines per-rail qualified faults, the all-off condition and input lockout
// into one registered open-drain power-good pin model.
// Assumes: rail_en, core_slewing, uvlo_active and backup_ok are synchronous
// to clk; rail_ok_async may be asynchronous.
module pgc_combiner #(
    parameter int unsigned NUM_RAILS     = 6,
    parameter int unsigned CORE_IDX      = 2,
    parameter int unsigned SETTLE_CYCLES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_en,
    input  logic [NUM_RAILS-1:0] rail_ok_async,
    input  logic                 core_slewing,
    input  logic                 uvlo_active,
    input  logic                 backup_ok,
    output logic                 pg_pin_level,
    output logic                 pg_pull_en
);

    logic [NUM_RAILS-1:0] rail_ok_s;
    logic [NUM_RAILS-1:0] rail_fault;
    logic                 none_enabled;
    logic                 any_fault;
    logic                 pull_q;

    pgc_sync #(.WIDTH(NUM_RAILS)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rail_ok_async),
        .q_sync  (rail_ok_s)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        pgc_rail_qual #(
            .SETTLE_CYCLES (SETTLE_CYCLES),
            .IS_CORE       (g == CORE_IDX)
        ) qual_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (rail_en[g]),
            .ok_s  (rail_ok_s[g]),
            .busy  (core_slewing),
            .fault (rail_fault[g])
        );
    end

    assign none_enabled = ~|rail_en;
    assign any_fault    = (|rail_fault) | none_enabled | uvlo_active;

    // Purpose: register the pin drive; reset holds the pin low.
    always_ff @(posedge clk) begin
        if (!rst_n) pull_q <= 1'b1;
        else        pull_q <= any_fault & backup_ok;
    end

    assign pg_pull_en   = pull_q;
    assign pg_pin_level = ~pull_q;

endmodule

// File: rtl/pgc_combiner_chk.sv
// Module pgc_combiner_chk
// Port-level properties of the power-good aggregator, bound into pgc_combiner.
// Assumes: same clock and reset as the design.
module pgc_combiner_chk #(
    parameter int unsigned NUM_RAILS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_RAILS-1:0] rail_en,
    input logic                 uvlo_active,
    input logic                 backup_ok,
    input logic                 pg_pull_en
);

    // R3
    all_off_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en == '0 && backup_ok) |=> pg_pull_en);

    // R6
    lockout_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_active && backup_ok) |=> pg_pull_en);

    // R7
    no_backup_floats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !backup_ok |=> !pg_pull_en);

    // R5
    enable_rise_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(rail_en & ~$past(rail_en))) && backup_ok) |=> pg_pull_en);

    // R5
    rise_holds_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(rail_en & ~$past(rail_en))) && backup_ok && $stable(backup_ok)) |=> ##1 ($past(backup_ok) -> pg_pull_en));

endmodule

bind pgc_combiner pgc_combiner_chk #(.NUM_RAILS(NUM_RAILS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rail_en     (rail_en),
    .uvlo_active (uvlo_active),
    .backup_ok   (backup_ok),
    .pg_pull_en  (pg_pull_en)
);

// File: tb/pgc_combiner_tb_top.sv
// Bench for pgc_combiner: a vector table walked by one loop, then directed tests.
module pgc_combiner_tb_top;

    localparam int unsigned NR     = 6;
    localparam int unsigned SETTLE = 4;
    localparam int unsigned HOLD   = 10;
    localparam int unsigned NVEC   = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NR-1:0] rail_en;
    logic [NR-1:0] rail_ok_async;
    logic          core_slewing;
    logic          uvlo_active;
    logic          backup_ok;
    logic          pg_pin_level;
    logic          pg_pull_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pgc_combiner #(.NUM_RAILS(NR), .CORE_IDX(2), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rail_en       (rail_en),
        .rail_ok_async (rail_ok_async),
        .core_slewing  (core_slewing),
        .uvlo_active   (uvlo_active),
        .backup_ok     (backup_ok),
        .pg_pin_level  (pg_pin_level),
        .pg_pull_en    (pg_pull_en)
    );

    // vector: en, ok, slewing, uvlo, backup, expected pull
    typedef struct packed {
        logic [NR-1:0] en;
        logic [NR-1:0] ok;
        logic          slew;
        logic          uvlo;
        logic          bkp;
        logic          exp_pull;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{6'h00, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 all off
        '{6'h3F, 6'h3F, 1'b0, 1'b0, 1'b1, 1'b0},  // R1 all good
        '{6'h3F, 6'h3E, 1'b0, 1'b0, 1'b1, 1'b1},  // R1 rail 0 bad
        '{6'h0F, 6'h0F, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 rails 4,5 off and bad
        '{6'h0F, 6'h2F, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 off rail flag toggled
        '{6'h0F, 6'h0B, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 core bad, not slewing
        '{6'h0F, 6'h0B, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 core bad, slewing masked
        '{6'h0F, 6'h0F, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 lockout
        '{6'h0F, 6'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R7 no backup floats
        '{6'h0F, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1},  // R1 backup back, all bad
        '{6'h20, 6'h20, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 single rail good
        '{6'h20, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1}   // R1 single rail bad
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp_pull);
        checks++;
        if (pg_pull_en !== exp_pull || pg_pin_level !== ~exp_pull) begin
            errors++;
            $display("FAIL %s: pull=%b level=%b expected pull=%b level=%b (R10 pairing)",
                     req, pg_pull_en, pg_pin_level, exp_pull, ~exp_pull);
        end
    endtask

    task automatic report();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            report();
        end
    end

    initial begin
        rst_n = 1'b0; rail_en = '0; rail_ok_async = '0;
        core_slewing = 1'b0; uvlo_active = 1'b0; backup_ok = 1'b1;
        step(3);
        check("R8 in reset", 1'b1);
        rst_n = 1'b1;
        step(1);
        check("R8 after reset", 1'b1);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            rail_en       = VECS[i].en;
            rail_ok_async = VECS[i].ok;
            core_slewing  = VECS[i].slew;
            uvlo_active   = VECS[i].uvlo;
            backup_ok     = VECS[i].bkp;
            step(HOLD);
            check($sformatf("R1/R2/R3/R4/R6/R7 vector %0d", i), VECS[i].exp_pull);
        end

        // R5: enable rise blanks for SETTLE+1 edges even with a good flag
        rail_en = '0; rail_ok_async = 6'h3F; core_slewing = 1'b0;
        uvlo_active = 1'b0; backup_ok = 1'b1;
        step(HOLD);
        rail_en = 6'h3F;
        step(1);
        check("R5 first edge after rise", 1'b1);
        step(SETTLE);
        check("R5 last blanked edge", 1'b1);
        step(1);
        check("R5 release after window", 1'b0);

        // R9: three-edge latency of the in-regulation flag
        rail_ok_async = 6'h3E;
        step(2);
        check("R9 still old after two edges", 1'b0);
        step(1);
        check("R9 new after third edge", 1'b1);

        // R4: slewing before first good reading masks nothing
        rail_en = '0; rail_ok_async = '0;
        step(HOLD);
        rail_en = 6'h04; core_slewing = 1'b1;
        step(HOLD);
        check("R4 slewing before first good", 1'b1);
        rail_ok_async = 6'h04;
        step(HOLD);
        check("R4 core good while slewing", 1'b0);
        rail_ok_async = 6'h00;
        step(HOLD);
        check("R4 core bad masked after good", 1'b0);
        core_slewing = 1'b0;
        step(1);
        check("R4 fault returns when slewing ends", 1'b1);

        // R7 overrides lockout and all-off
        rail_en = '0; uvlo_active = 1'b1; backup_ok = 1'b0;
        step(1);
        check("R7 floats over lockout", 1'b0);

        done = 1'b1;
        report();
    end

endmodule